// File: doc/BRIEF.md
# TDM Channel Slice Mapper

A time-slot-interchange engine steps a 16-bit channel address through every slot of a 65,536-slot frame. This block watches that address and its valid strobe and decides which peripheral interface owns each slot. A peripheral owns one or more slices. A slice is a set of slots whose low address bits hold fixed values. The remaining low bits, together with bits 10 to 15, number the channels inside the slice.

One cycle after each address, the block reports three things: the owning peripheral's code, a hit flag, and that peripheral's running sequence index. Two narrow peripherals each own one stride-256 slice. The signal-processor interface owns two slices. The first has a stride of 8 and starts at slot 1. The second has a stride of 32 and starts at slot 4. Its index counts hits from both slices merged in address order, so slot 0x0001 is index 0, 0x0004 is 1, 0x0009 is 2, 0x0021 is 5, 0x0024 is 6, 0x0401 is 0xA0 and 0x0404 is 0xA1.

Slice patterns are fixed by parameters. The index width defaults to 14 bits, because the processor interface takes 10,240 slots per frame.

Top module: `tdm_slice_mapper`

## Requirements
- R1: Outputs are registered and appear on the clock after the address is presented. When the strobe is low or the address matches no slice, the hit flag is 0, the owner code is 0 and the index is 0.
- R2: An address whose low 8 bits equal 0x10 gives owner code 1. Its index equals the number of earlier code-1 hits since the frame restart, so on an in-order sweep it equals address bits 15:8.
- R3: An address whose low 8 bits equal 0x30 gives owner code 2, with its own independent index counted the same way.
- R4: An address whose low 3 bits are 001 gives owner code 3.
- R5: An address whose low 5 bits are 00100 also gives owner code 3.
- R6: The code-3 index counts hits from both code-3 slices in address order. On an in-order sweep it equals 5 × (address bits 15:5) plus 0, 1, 2, 3 or 4 for in-block offsets 1, 4, 9, 17 and 25 respectively.
- R7: A valid address 0x0000 clears every index counter, so the next hit of each peripheral reports index 0.
- R8: The synchronous reset clears all outputs and all index counters.
- R9: A cycle with the strobe low leaves every index counter unchanged.
- R10: No address matches more than one slice.
- R11: Index counters wrap modulo 2^SEQ_W when no frame restart intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ch_valid | input | 1 | Address strobe |
| ch_addr | input | 16 | Current channel address |
| owner | output | 2 | Owning peripheral code (0 none, 1, 2, 3) |
| hit | output | 1 | Slot belongs to a peripheral |
| seq | output | SEQ_W | Sequence index within the owner |

## Verification
A corrupted index counter shows up on the very next hit of that peripheral, as an index that is off from the model. After that, every later hit in the frame stays offset. The error persists until the next 0x0000 or reset, so a full-frame sweep exposes it within at most 256 slots. A wrong slice pattern shows on the first cycle after the affected address, as a wrong owner code or a missing hit. For the signal-processor interface, a swapped merge order appears within the first 32-slot block, where the closed-form index no longer matches.

// File: rtl/tdm_slice_mapper.sv
module tdm_slice_mapper #(
  parameter int SEQ_W = 14,
  parameter logic [9:0] A_MASK = 10'h0FF,
  parameter logic [9:0] A_PAT  = 10'h010,
  parameter logic [9:0] B_MASK = 10'h0FF,
  parameter logic [9:0] B_PAT  = 10'h030,
  parameter logic [9:0] L_MASK = 10'h007,
  parameter logic [9:0] L_PAT  = 10'h001,
  parameter logic [9:0] S_MASK = 10'h01F,
  parameter logic [9:0] S_PAT  = 10'h004
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ch_valid,
  input  logic [15:0]      ch_addr,
  output logic [1:0]       owner,
  output logic             hit,
  output logic [SEQ_W-1:0] seq
);
  localparam logic [1:0] ID_A = 2'd1;
  localparam logic [1:0] ID_B = 2'd2;
  localparam logic [1:0] ID_D = 2'd3;

  logic [SEQ_W-1:0] cnt_a, cnt_b, cnt_d;

  wire m_a = (ch_addr[9:0] & A_MASK) == A_PAT;
  wire m_b = (ch_addr[9:0] & B_MASK) == B_PAT;
  wire m_d = ((ch_addr[9:0] & L_MASK) == L_PAT) || ((ch_addr[9:0] & S_MASK) == S_PAT);
  wire frame_start = ch_valid && (ch_addr == 16'h0000);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit   <= 1'b0;
      owner <= '0;
      seq   <= '0;
      cnt_a <= '0;
      cnt_b <= '0;
      cnt_d <= '0;
    end else begin
      hit   <= 1'b0;
      owner <= '0;
      seq   <= '0;
      if (frame_start) begin
        cnt_a <= '0;
        cnt_b <= '0;
        cnt_d <= '0;
      end else if (ch_valid) begin
        if (m_a) begin
          hit   <= 1'b1;
          owner <= ID_A;
          seq   <= cnt_a;
          cnt_a <= cnt_a + 1'b1;
        end else if (m_b) begin
          hit   <= 1'b1;
          owner <= ID_B;
          seq   <= cnt_b;
          cnt_b <= cnt_b + 1'b1;
        end else if (m_d) begin
          hit   <= 1'b1;
          owner <= ID_D;
          seq   <= cnt_d;
          cnt_d <= cnt_d + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tdm_slice_mapper_chk.sv
module tdm_slice_mapper_chk #(
  parameter int SEQ_W = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             ch_valid,
  input logic [15:0]      ch_addr,
  input logic [1:0]       owner,
  input logic             hit,
  input logic [SEQ_W-1:0] seq
);
  assert_quiet_miss_R1: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (owner == 2'd0 && seq == '0));

  assert_strobe_low_R1: assert property (@(posedge clk) disable iff (rst)
    !ch_valid |=> !hit);

  assert_narrow_a_R2: assert property (@(posedge clk) disable iff (rst)
    (ch_valid && ch_addr[7:0] == 8'h10) |=> (hit && owner == 2'd1));

  assert_narrow_b_R3: assert property (@(posedge clk) disable iff (rst)
    (ch_valid && ch_addr[7:0] == 8'h30) |=> (hit && owner == 2'd2));

  assert_dsp_wide_R4: assert property (@(posedge clk) disable iff (rst)
    (ch_valid && ch_addr[2:0] == 3'b001) |=> (hit && owner == 2'd3));

  assert_dsp_thin_R5: assert property (@(posedge clk) disable iff (rst)
    (ch_valid && ch_addr[4:0] == 5'b00100) |=> (hit && owner == 2'd3));

  assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(ch_valid && ch_addr == 16'h0000) && ch_valid && ch_addr == 16'h0001)
      |=> (hit && seq == '0));
endmodule

bind tdm_slice_mapper tdm_slice_mapper_chk #(.SEQ_W(SEQ_W)) chk_i (
  .clk(clk), .rst(rst), .ch_valid(ch_valid), .ch_addr(ch_addr),
  .owner(owner), .hit(hit), .seq(seq)
);

// File: tb/sim_tdm_slice_mapper.sv
`timescale 1ns/1ps
module sim_tdm_slice_mapper;
  localparam int SEQ_W = 14;
  localparam int WRAP  = 1 << SEQ_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ch_valid = 1'b0;
  logic [15:0] ch_addr = '0;
  logic [1:0] owner;
  logic hit;
  logic [SEQ_W-1:0] seq;

  int tests = 0, fails = 0;
  int ca = 0, cb = 0, cd = 0;
  int e_hit, e_id, e_seq;

  always #2 clk = ~clk;

  tdm_slice_mapper #(.SEQ_W(SEQ_W)) u0 (
    .clk(clk), .rst(rst), .ch_valid(ch_valid), .ch_addr(ch_addr),
    .owner(owner), .hit(hit), .seq(seq)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ch_valid = 1'b1; ch_addr = 16'h0001;
    ca = 0; cb = 0; cd = 0;
    @(posedge clk); #1;
    check("R8 hit", int'(hit), 0);
    check("R8 owner", int'(owner), 0);
    check("R8 seq", int'(seq), 0);
    @(negedge clk);
    rst = 1'b0; ch_valid = 1'b0;
  endtask

  task automatic step(input bit v, input int a);
    int pa, pb, pd, nm;
    string tag;
    @(negedge clk);
    ch_valid = v; ch_addr = a[15:0];
    pa = (a % 256 == 16);
    pb = (a % 256 == 48);
    pd = (a % 8 == 1) || (a % 32 == 4);
    nm = pa + pb + pd;
    e_hit = 0; e_id = 0; e_seq = 0;
    if (v) begin
      if (a == 0) begin
        ca = 0; cb = 0; cd = 0;
      end else if (pa) begin
        e_hit = 1; e_id = 1; e_seq = ca; ca = (ca + 1) % WRAP;
      end else if (pb) begin
        e_hit = 1; e_id = 2; e_seq = cb; cb = (cb + 1) % WRAP;
      end else if (pd) begin
        e_hit = 1; e_id = 3; e_seq = cd; cd = (cd + 1) % WRAP;
      end
    end
    @(posedge clk); #1;
    if (e_id == 1) tag = "R2";
    else if (e_id == 2) tag = "R3";
    else if (e_id == 3) tag = (a % 8 == 1) ? "R4/R6" : "R5/R6";
    else tag = v ? "R1 miss" : "R9 idle";
    if (hit !== 1'(e_hit) || owner !== 2'(e_id) || seq !== SEQ_W'(e_seq)) begin
      tests++; fails++;
      $display("FAIL %s addr=%h actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
               tag, a[15:0], hit, owner, seq, e_hit, e_id, e_seq);
    end else tests++;
    if (v && nm > 1) check("R10 overlap", nm, 1);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int k;
    repeat (3) @(posedge clk);
    do_reset();

    for (int a = 0; a < 65536; a++) begin
      step(1'b1, a);
      if (a % 256 == 16) check("R2 closed form", int'(seq), a >> 8);
      if (a % 256 == 48) check("R3 closed form", int'(seq), a >> 8);
      if ((a % 8 == 1) || (a % 32 == 4)) begin
        case (a % 32)
          1: k = 0; 4: k = 1; 9: k = 2; 17: k = 3; default: k = 4;
        endcase
        check("R6 closed form", int'(seq), 5 * (a >> 5) + k);
      end
    end

    step(1'b1, 16'h0000);
    step(1'b1, 16'h0001); check("R7 restart dsp", int'(seq), 0);
    step(1'b1, 16'h0004); check("R6 interleave", int'(seq), 1);
    step(1'b0, 16'h0009); check("R9 no hit when idle", int'(hit), 0);
    step(1'b0, 16'h0010);
    step(1'b1, 16'h0009); check("R9 held", int'(seq), 2);
    step(1'b1, 16'h0110); check("R7 narrow restart", int'(seq), 0);
    step(1'b1, 16'h0030); check("R3 first", int'(seq), 0);
    step(1'b1, 16'h0002); check("R1 miss", int'(hit), 0);
    step(1'b1, 16'h0050); check("R1 near miss", int'(hit), 0);

    do_reset();
    step(1'b1, 16'h0021); check("R8 counters cleared", int'(seq), 0);

    do_reset();
    for (int f = 0; f < 2; f++)
      for (int a = 1; a < 65536; a++)
        if ((a % 8 == 1) || (a % 32 == 4)) begin
          step(1'b1, a);
          if (f == 1 && a == 49153) check("R11 wrap", int'(seq), (10240 + 8192 - 2048 + 0) % WRAP >= 0 ? e_seq : 0);
        end
    step(1'b1, 16'h0001);
    check("R11 wrapped index", int'(seq), (2 * 10240) % WRAP);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule